// File: doc/BRIEF.md
# Address Break Match Unit

This block sits beside a CPU bus and compares every bus cycle against a programmed break address. A match sets an interrupt flag if the cycle is of the kind chosen by a condition select: instruction fetch, data read, data write, or either data direction. The flag drives an interrupt request when software has enabled it. Software clears the flag in two steps. It first reads the status register while the flag is 1, and then writes 0 to the flag bit.

The block also picks the byte lane of the 16-bit data bus that carries the accessed byte. The choice depends on the access size, the address parity and the target space. A word access to an 8-bit I/O register reaches the unit as two byte-lane cycles, and the unit evaluates each of them on its own. A small register port gives access to the status register, the break address and the condition select.

Top module: `brk_match_unit`

## Requirements
- R1: After reset the break address reads 0xFFFF. A write at register select 1 replaces all 16 bits, and reading at select 1 returns the written value.
- R2: For instruction fetches, the compared address is the address that the bus presents for the fetch, which is the first byte of the instruction. Only exact 16-bit equality with the break address is a match.
- R3: The flag (status bit 7) is 0 after reset. It becomes 1 on the clock edge that ends a valid, qualifying cycle whose address equals the break address. Nothing else sets it, and writing 1 to bit 7 has no effect.
- R4: Writing 0 to bit 7 clears the flag only if the status register was read (reg_rd with select 0) while the flag was 1, in an earlier cycle since the flag last set. Without such a read the flag is unchanged.
- R5: The enable (status bit 6) is 0 after reset and takes the value written to bit 6. irq is 1 exactly when the enable and the flag are both 1.
- R6: Status bits 5 to 0 always read as 1. Bits 15 to 8 of the status read are 0.
- R7: lane_byte is the lower byte bus_data[7:0] only for a word access at an odd address to ROM (space 0), RAM (1) or 16-bit I/O (3). In every other case it is the upper byte bus_data[15:8]. This includes all byte accesses and all accesses to 8-bit I/O (space 2).
- R8: Each bus cycle is judged on its own address. Of the two byte cycles that make up a word access to 8-bit I/O, only the one whose address equals the break address sets the flag.
- R9: The condition select (select 2, bits 1:0, reset 0) picks what qualifies. 0 means fetch (bus_cyc 0), 1 means read (bus_cyc 1), 2 means write (bus_cyc 2), and 3 means read or write. bus_cyc 3 is an idle cycle and never qualifies.
- R10: When a match and a clearing write fall in the same cycle, the flag stays 1. That match also discards the earlier read, so a later write of 0 needs a new read.
- R11: Register select 0 reads status, 1 reads the break address and 2 reads the condition select in bits 1:0. Select 3 reads 0. reg_rdata follows reg_sel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 16 | Bus cycle address |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| bus_cyc | input | 2 | 0 fetch, 1 data read, 2 data write, 3 idle |
| bus_space | input | 2 | 0 ROM, 1 RAM, 2 8-bit I/O, 3 16-bit I/O |
| bus_data | input | 16 | Data bus |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| lane_byte | output | 8 | Selected data byte lane (combinational) |
| irq | output | 1 | Address break interrupt request |

## Verification
reg_rdata and lane_byte follow their inputs within the same cycle. The flag, the enable, the read-seen marker and irq change on the first rising edge after the cycle that causes them. The bench drives inputs on the falling edge and compares every output 1 ns later. At that point the reference model has already taken the preceding rising edge, so the registered results are due, and the combinational ones reflect the new inputs. The directed checks look at the flag through a passive status select with no read strobe, which keeps the read-before-clear state untouched.

// File: rtl/brk_pkg.sv
// Shared encodings for the address break match unit.
// Assumes: the encodings below are fixed, because software and the bus decode them.
package brk_pkg;
    typedef enum logic [1:0] {
        CYC_FETCH = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2,
        CYC_IDLE  = 2'd3
    } cyc_e;

    typedef enum logic [1:0] {
        SP_ROM  = 2'd0,
        SP_RAM  = 2'd1,
        SP_IO8  = 2'd2,
        SP_IO16 = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        COND_FETCH = 2'd0,
        COND_READ  = 2'd1,
        COND_WRITE = 2'd2,
        COND_RDWR  = 2'd3
    } cond_e;

    localparam logic [1:0] SEL_STATUS = 2'd0;
    localparam logic [1:0] SEL_ADDR   = 2'd1;
    localparam logic [1:0] SEL_COND   = 2'd2;

    localparam int FLAG_BIT = 7;
    localparam int EN_BIT   = 6;
endpackage

// File: rtl/brk_cmp.sv
// Match detector: flags a bus cycle whose address equals the break address
// and whose cycle type is accepted by the condition select.
// Assumes: one bus cycle per clock, each judged on its own.
module brk_cmp #(
    parameter int ADDR_W = 16
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        cyc,
    input  logic [1:0]        cond,
    input  logic [ADDR_W-1:0] brk_addr,
    output logic              hit
);
    import brk_pkg::*;

    logic type_ok;

    // Decide whether this cycle type is accepted by the condition select.
    always_comb begin
        unique case (cond_e'(cond))
            COND_FETCH: type_ok = (cyc_e'(cyc) == CYC_FETCH);
            COND_READ:  type_ok = (cyc_e'(cyc) == CYC_READ);
            COND_WRITE: type_ok = (cyc_e'(cyc) == CYC_WRITE);
            default:    type_ok = (cyc_e'(cyc) == CYC_READ) || (cyc_e'(cyc) == CYC_WRITE);
        endcase
    end

    // Combine the cycle qualifier with exact address equality.
    always_comb begin
        hit = valid && type_ok && (addr == brk_addr);
    end
endmodule

// File: rtl/brk_lane.sv
// Byte lane picker: selects the half of the data bus that carries the accessed byte.
// Assumes: 8-bit I/O only drives the upper lane, and word accesses to 8-bit I/O
// arrive as separate byte-lane cycles.
module brk_lane #(
    parameter int DATA_W = 16
) (
    input  logic              word,
    input  logic              addr_lsb,
    input  logic [1:0]        space,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W/2-1:0] lane
);
    import brk_pkg::*;

    localparam int LANE_W = DATA_W / 2;

    logic use_low;

    // Only an odd word access on a full-width space uses the lower lane.
    always_comb begin
        use_low = word && addr_lsb && (space_e'(space) != SP_IO8);
    end

    // Steer the chosen half of the bus to the output.
    always_comb begin
        lane = use_low ? data[LANE_W-1:0] : data[DATA_W-1 -: LANE_W];
    end
endmodule

// File: rtl/brk_regs.sv
// Register file: break address, condition select, enable and the match flag,
// including the read-then-write-zero clearing rule.
// Assumes: ADDR_W <= DATA_W; the read strobe marks a status read.
module brk_regs #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              hit,
    output logic [ADDR_W-1:0] brk_addr,
    output logic [1:0]        cond,
    output logic              flag,
    output logic              en,
    output logic [DATA_W-1:0] reg_rdata
);
    import brk_pkg::*;

    localparam int RSV_W = EN_BIT;

    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        cond_q;
    logic              flag_q;
    logic              en_q;
    logic              seen_q;
    logic              wr_stat, rd_stat, clr;

    // Decode strobes for the status register and the clearing condition.
    always_comb begin
        wr_stat = reg_wr && (reg_sel == SEL_STATUS);
        rd_stat = reg_rd && (reg_sel == SEL_STATUS);
        clr     = wr_stat && !reg_wdata[FLAG_BIT] && seen_q && flag_q;
    end

    // Hold the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '1;
            cond_q <= COND_FETCH;
            en_q   <= 1'b0;
        end else begin
            if (reg_wr && reg_sel == SEL_ADDR) addr_q <= reg_wdata[ADDR_W-1:0];
            if (reg_wr && reg_sel == SEL_COND) cond_q <= reg_wdata[1:0];
            if (wr_stat)                       en_q   <= reg_wdata[EN_BIT];
        end
    end

    // Flag and read-seen tracking; a new match outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
            seen_q <= 1'b0;
        end else if (clr) begin
            flag_q <= 1'b0;
            seen_q <= 1'b0;
        end else if (rd_stat && flag_q) begin
            seen_q <= 1'b1;
        end
    end

    // Read mux for the register port.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_STATUS: begin
                reg_rdata[FLAG_BIT]  = flag_q;
                reg_rdata[EN_BIT]    = en_q;
                reg_rdata[RSV_W-1:0] = '1;
            end
            SEL_ADDR: reg_rdata[ADDR_W-1:0] = addr_q;
            SEL_COND: reg_rdata[1:0]        = cond_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign brk_addr = addr_q;
    assign cond     = cond_q;
    assign flag     = flag_q;
    assign en       = en_q;

    AST_RESET_VALUES: assert property (@(posedge clk) !rst_n |=> (addr_q == '1 && !flag_q && !en_q)); // R1
    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) hit |=> flag_q); // R3
    AST_SET_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag_q) |-> $past(hit)); // R3
    AST_NO_BLIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (flag_q && !seen_q) |=> flag_q); // R4
    AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(reg_wr && reg_sel == SEL_STATUS && !reg_wdata[FLAG_BIT])); // R4
    AST_RESERVED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_STATUS) |-> (reg_rdata[RSV_W-1:0] == '1)); // R6
endmodule

// File: rtl/brk_match_unit.sv
// Address break match unit top: ties the match detector, the lane picker and
// the register file together and forms the interrupt request.
// Assumes: synchronous active-low reset; bus inputs are stable around the clock edge.
module brk_match_unit #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_word,
    input  logic [1:0]        bus_cyc,
    input  logic [1:0]        bus_space,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [1:0]        reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [DATA_W/2-1:0] lane_byte,
    output logic              irq
);
    import brk_pkg::*;

    logic [ADDR_W-1:0] brk_addr;
    logic [1:0]        cond;
    logic              hit, flag, en;

    brk_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .valid    (bus_valid),
        .addr     (bus_addr),
        .cyc      (bus_cyc),
        .cond     (cond),
        .brk_addr (brk_addr),
        .hit      (hit)
    );

    brk_lane #(.DATA_W(DATA_W)) u_lane (
        .word     (bus_word),
        .addr_lsb (bus_addr[0]),
        .space    (bus_space),
        .data     (bus_data),
        .lane     (lane_byte)
    );

    brk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .hit       (hit),
        .brk_addr  (brk_addr),
        .cond      (cond),
        .flag      (flag),
        .en        (en),
        .reg_rdata (reg_rdata)
    );

    // Request an interrupt while the flag is up and enabled.
    always_comb begin
        irq = flag && en;
    end

    AST_IO8_UPPER_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_space == SP_IO8) |-> (lane_byte == bus_data[DATA_W-1 -: DATA_W/2])); // R7
    AST_BYTE_UPPER_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_word |-> (lane_byte == bus_data[DATA_W-1 -: DATA_W/2])); // R7
    AST_IDLE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && (!bus_valid || bus_cyc == CYC_IDLE)) |=> !flag); // R9
endmodule

// File: tb/brk_match_unit_test.sv
`timescale 1ns/100ps
module brk_match_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_word = 1'b0;
    logic [1:0]  bus_cyc = 2'd3;
    logic [1:0]  bus_space = 2'd0;
    logic [15:0] bus_data = '0;
    logic [1:0]  reg_sel = 2'd0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  lane_byte;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    logic [15:0] m_addr = 16'hFFFF;
    logic [1:0]  m_cond = 2'd0;
    bit m_flag = 0, m_en = 0, m_seen = 0;

    always #2.5 clk = ~clk;

    brk_match_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_word(bus_word), .bus_cyc(bus_cyc), .bus_space(bus_space), .bus_data(bus_data),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .lane_byte(lane_byte), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit cyc_ok(input logic [1:0] c, input logic [1:0] k);
        case (c)
            2'd0: return k == 2'd0;
            2'd1: return k == 2'd1;
            2'd2: return k == 2'd2;
            default: return (k == 2'd1) || (k == 2'd2);
        endcase
    endfunction

    // Model: advance state on each rising edge
    always @(posedge clk) begin
        bit hit, clr;
        hit = bus_valid && (bus_addr == m_addr) && cyc_ok(m_cond, bus_cyc);
        clr = reg_wr && reg_sel == 2'd0 && !reg_wdata[7] && m_seen && m_flag;
        if (!rst_n) begin
            m_addr = 16'hFFFF; m_cond = 0; m_flag = 0; m_en = 0; m_seen = 0;
        end else begin
            if (hit) begin m_flag = 1; m_seen = 0; end
            else if (clr) begin m_flag = 0; m_seen = 0; end
            else if (reg_rd && reg_sel == 2'd0 && m_flag) m_seen = 1;
            if (reg_wr && reg_sel == 2'd1) m_addr = reg_wdata;
            if (reg_wr && reg_sel == 2'd2) m_cond = reg_wdata[1:0];
            if (reg_wr && reg_sel == 2'd0) m_en = reg_wdata[6];
        end
    end

    // Compare every output shortly after each falling edge
    always begin
        logic [15:0] e_rd;
        logic [7:0]  e_lane;
        @(negedge clk);
        #1;
        case (reg_sel)
            2'd0: e_rd = {8'h00, m_flag, m_en, 6'h3F};
            2'd1: e_rd = m_addr;
            2'd2: e_rd = {14'd0, m_cond};
            default: e_rd = 16'h0000;
        endcase
        if (bus_word && bus_addr[0] && bus_space != 2'd2) e_lane = bus_data[7:0];
        else e_lane = bus_data[15:8];
        if (rst_n) begin
            check("R11 reg_rdata", reg_rdata, e_rd);
            check("R7 lane_byte", {8'h00, lane_byte}, {8'h00, e_lane});
            check("R5 irq", {15'd0, irq}, {15'd0, m_flag && m_en});
        end
    end

    task automatic idle_inputs();
        bus_valid = 0; bus_cyc = 2'd3; reg_wr = 0; reg_rd = 0;
    endtask

    task automatic bus(input logic [15:0] a, input logic [1:0] c,
                       input logic w = 0, input logic [1:0] s = 0, input logic [15:0] d = 16'hA55A);
        @(negedge clk);
        idle_inputs();
        bus_valid = 1; bus_addr = a; bus_cyc = c; bus_word = w; bus_space = s; bus_data = d;
    endtask

    task automatic regw(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        idle_inputs();
        reg_sel = s; reg_wr = 1; reg_wdata = d;
    endtask

    task automatic regr(input logic [1:0] s);
        @(negedge clk);
        idle_inputs();
        reg_sel = s; reg_rd = 1;
    endtask

    // Passive look at the flag: select status without the read strobe
    task automatic expect_flag(input string tag, input bit exp);
        @(negedge clk);
        idle_inputs();
        reg_sel = 2'd0;
        #1;
        check(tag, {15'd0, reg_rdata[7]}, {15'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 R5 R6 reset values
        @(negedge clk); idle_inputs(); reg_sel = 2'd0; #1;
        check("R6 status after reset", reg_rdata, 16'h003F);
        check("R5 irq after reset", {15'd0, irq}, 16'd0);
        @(negedge clk); reg_sel = 2'd1; #1;
        check("R1 break addr reset", reg_rdata, 16'hFFFF);
        regw(2'd1, 16'h1234);
        @(negedge clk); idle_inputs(); reg_sel = 2'd1; #1;
        check("R1 break addr readback", reg_rdata, 16'h1234);
        // R9: read cycle does not qualify under fetch select
        bus(16'h1234, 2'd1);
        expect_flag("R9 read ignored under fetch", 0);
        // R2: neighbouring fetch address does not match; exact one does
        bus(16'h1235, 2'd0);
        expect_flag("R2 off-by-one fetch", 0);
        bus(16'h1234, 2'd0);
        expect_flag("R3 fetch match sets flag", 1);
        // R5: enable with a zero flag bit; no prior read, so R4 keeps the flag
        regw(2'd0, 16'h0040);
        expect_flag("R4 write 0 without read", 1);
        @(negedge clk); #1;
        check("R5 irq enabled", {15'd0, irq}, 16'd1);
        regw(2'd0, 16'h00C0);
        expect_flag("R3 write 1 no effect", 1);
        regr(2'd0);
        regw(2'd0, 16'h0040);
        expect_flag("R4 read then write 0 clears", 0);
        // R9 condition select variants
        regw(2'd2, 16'h0002);
        bus(16'h1234, 2'd1);
        expect_flag("R9 read ignored under write", 0);
        bus(16'h1234, 2'd3);
        expect_flag("R9 idle never qualifies", 0);
        bus(16'h1234, 2'd2);
        expect_flag("R9 write match", 1);
        regr(2'd0); regw(2'd0, 16'h0040);
        regw(2'd2, 16'h0003);
        bus(16'h1234, 2'd0);
        expect_flag("R9 fetch ignored under read-or-write", 0);
        bus(16'h1234, 2'd1);
        expect_flag("R9 read match under read-or-write", 1);
        // R10: clear collides with a match
        regr(2'd0);
        @(negedge clk);
        idle_inputs();
        reg_sel = 2'd0; reg_wr = 1; reg_wdata = 16'h0040;
        bus_valid = 1; bus_addr = 16'h1234; bus_cyc = 2'd2;
        expect_flag("R10 set wins over clear", 1);
        regw(2'd0, 16'h0040);
        expect_flag("R10 match discards earlier read", 1);
        regr(2'd0); regw(2'd0, 16'h0040);
        expect_flag("R4 clear after fresh read", 0);
        // R8: word to 8-bit I/O as two byte cycles
        regw(2'd1, 16'h2001);
        bus(16'h2000, 2'd1, 1, 2'd2, 16'hBEEF);
        expect_flag("R8 first byte cycle no match", 0);
        bus(16'h2001, 2'd1, 1, 2'd2, 16'hC0DE);
        #1.5; check("R7 io8 odd word upper lane", {8'h00, lane_byte}, 16'h00C0);
        expect_flag("R8 second byte cycle matches", 1);
        // R7 lane sweep
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 2; w++)
                for (int p = 0; p < 2; p++) begin
                    bus(16'h4000 | p[15:0], 2'd3, w[0], s[1:0], 16'h9A3C);
                    #1.5;
                    check("R7 lane sweep", {8'h00, lane_byte},
                          (w == 1 && p == 1 && s != 2) ? 16'h003C : 16'h009A);
                end
        // R11 select 3 reads zero
        @(negedge clk); idle_inputs(); reg_sel = 2'd3; #1;
        check("R11 unused select", reg_rdata, 16'h0000);
        // Mixed random traffic compared against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            idle_inputs();
            bus_valid = $urandom_range(0, 1);
            bus_addr  = $urandom_range(0, 1) ? m_addr : 16'(m_addr ^ $urandom_range(0, 3));
            bus_cyc   = 2'($urandom_range(0, 3));
            bus_word  = $urandom_range(0, 1);
            bus_space = 2'($urandom_range(0, 3));
            bus_data  = 16'($urandom);
            reg_sel   = 2'($urandom_range(0, 3));
            reg_rd    = ($urandom_range(0, 3) == 0);
            reg_wr    = ($urandom_range(0, 5) == 0);
            reg_wdata = 16'($urandom);
            if (reg_wr && reg_sel == 2'd1 && $urandom_range(0, 1)) reg_wdata = m_addr;
        end
        @(negedge clk); idle_inputs();
        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule